// File: doc/BRIEF.md
# Video Sync Presence Detector

This block decides whether a train of video sync pulses is arriving on the currently selected input and reports the verdict on a single status flag. The sync input is an already-sliced digital pulse stream. It is brought into the clock domain through two flip-flops, and each rising edge is treated as one sync pulse.

A mode bit selects between two behaviours. In sticky mode, the first pulse sets the flag. The flag stays set until software reads the status register. In window mode, a free-running timer divides time into windows of `WIN_CYC` clock cycles. The block counts pulses inside each window and compares the count with `THRESH`. The flag changes only when two consecutive windows agree, and the change takes effect half a window after the second of those windows closes. A write to the source-select register clears the flag. That write also restarts the window timer and discards any window history or pending change. Nothing else restarts the timer. The interrupt mask input is accepted on the port but has no influence on the flag.

Top module: `sync_presence_det`

## Requirements
- R1: While reset is asserted, and directly after it is released, `present` is 0.
- R2: With `mode_win`=0, a rising edge on `sync_in` sets `present` to 1 on the third clock edge after the edge is sampled. The first two edges pass through the two-flop synchronizer and the third is the flag register.
- R3: A cycle with `src_wr`=1 forces `present` to 0 on the next clock edge in either mode, even if a pulse arrives in that same cycle.
- R4: With `mode_win`=0, `stat_rd`=1 clears `present` on the next edge. If a synchronized rising edge is seen in the same cycle as the read, the set wins and `present` stays 1.
- R5: The window timer runs freely with period `WIN_CYC`. Only reset and `src_wr` restart it, and `src_wr` also forgets the result of the previous window.
- R6: With `mode_win`=1, two consecutive windows that each count at least `THRESH` pulses make `present` 1. The change happens exactly `WIN_CYC/2` cycles after the clock edge that closes the second window.
- R7: With `mode_win`=1, two consecutive windows that each count fewer than `THRESH` pulses make `present` 0, with the same half-window delay.
- R8: A single window whose result differs from the window before it leaves `present` unchanged.
- R9: The per-window pulse counter saturates at `THRESH` and never wraps, so a very dense burst still counts as a qualifying window.
- R10: `irq_mask` has no effect on `present` in either mode.
- R11: With `mode_win`=1, `stat_rd` has no effect on `present`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Digitized sync pulse stream (asynchronous) |
| mode_win | input | 1 | 0 selects sticky mode, 1 selects window mode |
| stat_rd | input | 1 | Status-register read strobe, one cycle |
| src_wr | input | 1 | Source-select register write strobe, one cycle |
| irq_mask | input | 1 | Interrupt mask bit; does not affect the flag |
| present | output | 1 | Sync-present flag |

## Verification
In sticky mode, a read strobe and a synchronized rising edge can land in the same cycle. The read must then lose, so the pulse is not dropped. In window mode, a source-select write can coincide with a window close or with the final cycle of a pending delayed update, and the write must cancel both. Random read, write and pulse traffic provokes these collisions repeatedly. A cycle-level reference model in the bench, built from the requirements, compares the flag in every cycle. Directed sequences aligned to known window boundaries then pin the rise, the fall and the single-window case.

// File: rtl/sync_presence_det.sv
module sync_presence_det #(
  parameter int WIN_CYC = 1000000,
  parameter int THRESH  = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic mode_win,
  input  logic stat_rd,
  input  logic src_wr,
  input  logic irq_mask,
  output logic present
);
  localparam int TW   = $clog2(WIN_CYC);
  localparam int CW   = $clog2(THRESH + 1);
  localparam int HALF = WIN_CYC / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [2:0]    sq;
  logic          sync_rise;
  logic [TW-1:0] tmr;
  logic          last;
  logic [CW-1:0] cnt, cnt_inc;
  logic          qual;
  logic          hist_v, hist_q;
  logic          pend, tgt;
  logic [DW-1:0] dly;
  logic          unused_mask;

  assign unused_mask = irq_mask;
  assign sync_rise   = sq[1] & ~sq[2];
  assign last        = (tmr == TW'(WIN_CYC - 1));
  assign cnt_inc     = (sync_rise && cnt != CW'(THRESH)) ? cnt + CW'(1) : cnt;
  assign qual        = (cnt_inc == CW'(THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= {sq[1:0], sync_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      cnt     <= '0;
      hist_v  <= 1'b0;
      hist_q  <= 1'b0;
      pend    <= 1'b0;
      tgt     <= 1'b0;
      dly     <= '0;
      present <= 1'b0;
    end else if (src_wr) begin
      tmr     <= '0;
      cnt     <= '0;
      hist_v  <= 1'b0;
      hist_q  <= 1'b0;
      pend    <= 1'b0;
      dly     <= '0;
      present <= 1'b0;
    end else begin
      if (!mode_win) begin
        if (sync_rise)    present <= 1'b1;
        else if (stat_rd) present <= 1'b0;
      end
      if (last) begin
        tmr    <= '0;
        cnt    <= '0;
        hist_v <= 1'b1;
        hist_q <= qual;
        if (hist_v && hist_q == qual) begin
          pend <= 1'b1;
          tgt  <= qual;
          dly  <= '0;
        end
      end else begin
        tmr <= tmr + TW'(1);
        cnt <= cnt_inc;
        if (pend) begin
          if (dly == DW'(HALF - 1)) begin
            pend <= 1'b0;
            if (mode_win) present <= tgt;
          end else begin
            dly <= dly + DW'(1);
          end
        end
      end
    end
  end
endmodule

module sync_presence_det_chk #(
  parameter int WIN_CYC = 1000000,
  parameter int THRESH  = 384
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         mode_win,
  input logic                         stat_rd,
  input logic                         src_wr,
  input logic                         sync_rise,
  input logic                         pend,
  input logic [$clog2(THRESH+1)-1:0]  cnt,
  input logic [$clog2(WIN_CYC)-1:0]   tmr,
  input logic                         present
);
  a_r3_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr |=> !present);
  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_win && sync_rise && !src_wr) |=> present);
  a_r4_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_win && present && !stat_rd && !src_wr) |=> present);
  a_r11_window_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_win && !pend && !src_wr) |=> $stable(present));
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(THRESH+1))'(THRESH));
  a_r5_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= ($clog2(WIN_CYC))'(WIN_CYC - 1));
  a_r5_wr_restarts_timer: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr |=> (tmr == '0));
endmodule

bind sync_presence_det sync_presence_det_chk #(.WIN_CYC(WIN_CYC), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_win(mode_win), .stat_rd(stat_rd), .src_wr(src_wr),
  .sync_rise(sync_rise), .pend(pend), .cnt(cnt), .tmr(tmr), .present(present)
);

// File: tb/sim_sync_presence_det.sv
module sim_sync_presence_det;
  localparam int WIN  = 200;
  localparam int TH   = 8;
  localparam int HALF = WIN / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_in = 1'b0, mode_win = 1'b0, stat_rd = 1'b0, src_wr = 1'b0, irq_mask = 1'b0;
  logic present;

  int checks = 0, fails = 0, since_wr = 0, rate = 0;
  bit finished = 1'b0;

  sync_presence_det #(.WIN_CYC(WIN), .THRESH(TH)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mode_win(mode_win), .stat_rd(stat_rd),
    .src_wr(src_wr), .irq_mask(irq_mask), .present(present));

  always #4 clk = ~clk;

  function automatic int sat_add(input int c, input bit e);
    return (c + e > TH) ? TH : c + e;
  endfunction

  // reference model built from the requirements
  bit m_s1, m_s2, m_s3, m_hv, m_hq, m_pend, m_tgt, m_flag;
  int m_tmr, m_cnt, m_dly;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_s3, m_hv, m_hq, m_pend, m_tgt, m_flag} = '0;
      m_tmr = 0; m_cnt = 0; m_dly = 0;
    end else begin
      bit e, q;
      int inc;
      e = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      if (src_wr) begin
        m_tmr = 0; m_cnt = 0; m_hv = 0; m_hq = 0; m_pend = 0; m_dly = 0; m_flag = 0;
      end else begin
        inc = sat_add(m_cnt, e);
        if (!mode_win) begin
          if (e) m_flag = 1;
          else if (stat_rd) m_flag = 0;
        end
        if (m_tmr == WIN - 1) begin
          q = (inc >= TH);
          if (m_hv && m_hq == q) begin m_pend = 1; m_tgt = q; m_dly = 0; end
          m_hv = 1; m_hq = q; m_tmr = 0; m_cnt = 0;
        end else begin
          m_tmr++; m_cnt = inc;
          if (m_pend) begin
            if (m_dly == HALF - 1) begin
              m_pend = 0;
              if (mode_win) m_flag = m_tgt;
            end else m_dly++;
          end
        end
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: present=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit r, input bit w, input bit m, input string tag);
    @(negedge clk);
    check(present, m_flag, tag);
    sync_in = s; stat_rd = r; src_wr = w; irq_mask = m;
    since_wr = w ? 0 : since_wr + 1;
  endtask

  function automatic bit rnd_sync();
    return ($urandom_range(99) < rate);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(present, 1'b0, "R1");
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    check(present, 1'b0, "R1");

    // sticky mode directed
    repeat (4) step(1, 0, 0, 0, "R2");
    @(negedge clk); check(present, 1'b1, "R2");
    step(1, 1, 0, 0, "R4");
    step(0, 0, 0, 0, "R4");
    @(negedge clk); check(present, 1'b0, "R4");
    repeat (2) step(0, 0, 0, 0, "R2");
    repeat (4) step(1, 0, 0, 0, "R2");
    for (int i = 0; i < 10; i++) step(1, 0, 0, i[0], "R10");
    @(negedge clk); check(present, 1'b1, "R10");
    step(1, 0, 1, 0, "R3");
    step(1, 0, 0, 0, "R3");
    @(negedge clk); check(present, 1'b0, "R3");

    // sticky mode random, reads colliding with edges
    rate = 30;
    for (int i = 0; i < 3000; i++)
      step(rnd_sync(), $urandom_range(3) == 0, $urandom_range(200) == 0, $urandom_range(1), "R4");

    // window mode directed, aligned to known windows
    mode_win = 1'b1;
    step(0, 0, 1, 0, "R5");
    rate = 30;
    while (since_wr < 1000) step(rnd_sync(), 0, 0, $urandom_range(1), "R6");
    @(negedge clk); check(present, 1'b1, "R6");
    rate = 0;
    step(0, 1, 0, 0, "R11");
    step(0, 0, 0, 0, "R11");
    @(negedge clk); check(present, 1'b1, "R11");
    while (since_wr < 1200) step(rnd_sync(), 0, 0, 0, "R8");
    rate = 40;
    while (since_wr < 1600) step(rnd_sync(), 0, 0, 0, "R9");
    @(negedge clk); check(present, 1'b1, "R8");
    rate = 0;
    while (since_wr < 2400) step(rnd_sync(), 0, 0, 1, "R7");
    @(negedge clk); check(present, 1'b0, "R7");

    // window mode random
    for (int i = 0; i < 15000; i++) begin
      if ($urandom_range(300) == 0) begin
        case ($urandom_range(2))
          0: rate = 0;
          1: rate = 2;
          default: rate = 35;
        endcase
      end
      step(rnd_sync(), $urandom_range(4) == 0, $urandom_range(3000) == 0, $urandom_range(1), "R6");
    end
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end
endmodule